// File: doc/BRIEF.md
# Per-Wavefront Memory Request Credit Limiter

This block decides, one instruction at a time, whether a vector global memory instruction from a given wavefront may be issued. For every wavefront it tracks how many read-type and how many write-type operations are still outstanding, and it holds a single pool of coalescer tokens shared by all wavefronts. A request is granted only when the requesting wavefront still has room under its outstanding limit and the pool still holds a token.

A granted instruction takes one token and raises the counters that match its class. When the memory side signals a completion, the same class rules lower the counters again. Tokens come back on a separate one-per-cycle return input. An instruction whose lane mask is entirely zero produces no memory traffic, so its token is handed straight back in the same cycle it is granted. Its counters still rise and are lowered by a later completion.

Top module: `wf_credit_limiter`

## Requirements
- R1: A request on `iss_valid` is granted when the wavefront's read count plus write count is below `MAX_REQ` and the token pool is non-empty. Otherwise it is refused. The decision uses the state before the current edge, and `iss_grant` is high in the cycle after the request.
- R2: The 2-bit operation class is 0 for load, 1 for store, 2 for atomic and 3 for memory sync. A granted load raises the read count. A granted store raises the write count. An atomic or a sync raises both counts.
- R3: A completion lowers the counts of its wavefront by the class rules of R2, so an atomic or a sync completion releases both counts.
- R4: The pool starts full at `TOKENS`. Each grant with a non-zero lane mask removes one token, and a request that arrives while the pool is empty is refused.
- R5: A grant with `iss_lanes_zero` high leaves the token pool unchanged.
- R6: Each cycle with `tok_ret` high adds one token, and the pool saturates at `TOKENS`.
- R7: An issue and a completion for the same wavefront in the same cycle are both applied to its counts.
- R8: A completion that would lower a count that is already zero leaves that count at zero and sets `err_underflow`. The flag stays set until reset.
- R9: After synchronous reset, `iss_grant` and `err_underflow` are low, all counts are zero and the pool is full.
- R10: The counts of one wavefront do not affect the grants of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request present |
| iss_wf | input | $clog2(NUM_WF) | Wavefront of the request |
| iss_op | input | 2 | Class of the request (0 load, 1 store, 2 atomic, 3 sync) |
| iss_lanes_zero | input | 1 | Request has an all-zero lane mask |
| cmp_valid | input | 1 | Completion event present |
| cmp_wf | input | $clog2(NUM_WF) | Wavefront of the completion |
| cmp_op | input | 2 | Class of the completed instruction |
| tok_ret | input | 1 | One token returned this cycle |
| iss_grant | output | 1 | Registered grant for the previous cycle's request |
| err_underflow | output | 1 | Sticky flag set by a completion with nothing outstanding |

## Verification
A wrong count shows at the ports as a grant edge in the wrong place. A count that is too high refuses a wavefront early, and a lost increment lets through one request too many. Either error is visible on the first request made at the limit, one cycle after that request. A wrong token count shows only when the pool nears empty, so the bench drains all 64 tokens and then checks that the first refusal and the first re-grant after a return come exactly where the token arithmetic predicts. A count that wraps on underflow shows as an early refusal within the next `MAX_REQ` requests of that wavefront.

// File: rtl/wfcl_pkg.sv
package wfcl_pkg;
  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_ATOMIC = 2'd2,
    OP_SYNC   = 2'd3
  } mem_op_e;

  // class touches the read counter
  function automatic logic op_reads(input mem_op_e k);
    return k != OP_STORE;
  endfunction

  // class touches the write counter
  function automatic logic op_writes(input mem_op_e k);
    return k != OP_LOAD;
  endfunction
endpackage

// File: rtl/wfcl_counter.sv
module wfcl_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] count,
  output logic          underflow
);
  logic          can_dec;
  logic [CW-1:0] next_count;

  always_comb begin
    can_dec    = dec && (count != '0);
    underflow  = dec && (count == '0);
    next_count = count + {{(CW-1){1'b0}}, inc} - {{(CW-1){1'b0}}, can_dec};
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= next_count;
  end
endmodule

// File: rtl/wfcl_wave_slot.sv
module wfcl_wave_slot
  import wfcl_pkg::*;
#(
  parameter int MAX_REQ = 8,
  parameter int CW      = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    issue_en,
  input  mem_op_e issue_op,
  input  logic    done_en,
  input  mem_op_e done_op,
  output logic    at_limit,
  output logic    underflow
);
  localparam int SW = CW + 1;

  logic [CW-1:0] rd_cnt, wr_cnt;
  logic          rd_uf, wr_uf;
  logic [SW-1:0] total;

  wfcl_counter #(.CW(CW)) u_rd (
    .clk(clk), .rst(rst),
    .inc(issue_en && op_reads(issue_op)),
    .dec(done_en && op_reads(done_op)),
    .count(rd_cnt), .underflow(rd_uf)
  );

  wfcl_counter #(.CW(CW)) u_wr (
    .clk(clk), .rst(rst),
    .inc(issue_en && op_writes(issue_op)),
    .dec(done_en && op_writes(done_op)),
    .count(wr_cnt), .underflow(wr_uf)
  );

  always_comb begin
    total     = {1'b0, rd_cnt} + {1'b0, wr_cnt};
    at_limit  = total >= SW'(MAX_REQ);
    underflow = rd_uf || wr_uf;
  end
endmodule

// File: rtl/wfcl_token_pool.sv
module wfcl_token_pool #(
  parameter int TOKENS = 64,
  parameter int TW     = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          give,
  output logic [TW-1:0] count,
  output logic          avail
);
  logic [TW:0] sum;

  always_comb begin
    avail = count != '0;
    sum   = {1'b0, count} + {{TW{1'b0}}, give} - {{TW{1'b0}}, take};
  end

  always_ff @(posedge clk) begin
    if (rst)                          count <= TW'(TOKENS);
    else if (sum > (TW+1)'(TOKENS))   count <= TW'(TOKENS);
    else                              count <= sum[TW-1:0];
  end
endmodule

// File: rtl/wf_credit_limiter.sv
module wf_credit_limiter
  import wfcl_pkg::*;
#(
  parameter int NUM_WF  = 4,
  parameter int MAX_REQ = 8,
  parameter int TOKENS  = 64,
  localparam int WW     = (NUM_WF > 1) ? $clog2(NUM_WF) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iss_valid,
  input  logic [WW-1:0] iss_wf,
  input  logic [1:0]    iss_op,
  input  logic          iss_lanes_zero,
  input  logic          cmp_valid,
  input  logic [WW-1:0] cmp_wf,
  input  logic [1:0]    cmp_op,
  input  logic          tok_ret,
  output logic          iss_grant,
  output logic          err_underflow
);
  localparam int CW = $clog2(MAX_REQ + 2);
  localparam int TW = $clog2(TOKENS + 1);

  logic [NUM_WF-1:0] limit_vec, uf_vec;
  logic [TW-1:0]     tok_cnt;
  logic              tok_avail;
  logic              grant_now;

  always_comb begin
    grant_now = iss_valid && !limit_vec[iss_wf] && tok_avail;
  end

  for (genvar w = 0; w < NUM_WF; w++) begin : g_wave
    wfcl_wave_slot #(.MAX_REQ(MAX_REQ), .CW(CW)) u_slot (
      .clk(clk), .rst(rst),
      .issue_en(grant_now && (iss_wf == WW'(w))),
      .issue_op(mem_op_e'(iss_op)),
      .done_en(cmp_valid && (cmp_wf == WW'(w))),
      .done_op(mem_op_e'(cmp_op)),
      .at_limit(limit_vec[w]),
      .underflow(uf_vec[w])
    );
  end

  wfcl_token_pool #(.TOKENS(TOKENS), .TW(TW)) u_pool (
    .clk(clk), .rst(rst),
    .take(grant_now && !iss_lanes_zero),
    .give(tok_ret),
    .count(tok_cnt),
    .avail(tok_avail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_grant     <= 1'b0;
      err_underflow <= 1'b0;
    end else begin
      iss_grant     <= grant_now;
      err_underflow <= err_underflow || (|uf_vec);
    end
  end
endmodule

// File: rtl/wfcl_checker.sv
module wfcl_checker #(
  parameter int TOKENS = 64,
  parameter int TW     = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          iss_valid,
  input logic          tok_ret,
  input logic          iss_grant,
  input logic          err_underflow,
  input logic [TW-1:0] tok_cnt
);
  assert_grant_has_request_R1: assert property (@(posedge clk) disable iff (rst)
    iss_grant |-> $past(iss_valid));

  assert_grant_has_token_R4: assert property (@(posedge clk) disable iff (rst)
    iss_grant |-> ($past(tok_cnt) != '0));

  assert_pool_idle_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (!iss_valid && !tok_ret) |=> (tok_cnt == $past(tok_cnt)));

  assert_pool_refill_R6: assert property (@(posedge clk) disable iff (rst)
    (tok_ret && !iss_valid && (tok_cnt < TW'(TOKENS))) |=> (tok_cnt == $past(tok_cnt) + 1'b1));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    tok_cnt <= TW'(TOKENS));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    err_underflow |=> err_underflow);
endmodule

bind wf_credit_limiter wfcl_checker #(.TOKENS(TOKENS), .TW(TW)) u_chk (
  .clk(clk), .rst(rst), .iss_valid(iss_valid), .tok_ret(tok_ret),
  .iss_grant(iss_grant), .err_underflow(err_underflow), .tok_cnt(tok_cnt)
);

// File: tb/wf_credit_limiter_test.sv
`timescale 1ns/1ps
module wf_credit_limiter_test;
  localparam int NUM_WF  = 4;
  localparam int MAX_REQ = 8;
  localparam int TOKENS  = 64;
  localparam int WW      = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iss_valid = 0, iss_lanes_zero = 0, cmp_valid = 0, tok_ret = 0;
  logic [WW-1:0] iss_wf = 0, cmp_wf = 0;
  logic [1:0] iss_op = 0, cmp_op = 0;
  logic iss_grant, err_underflow;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  wf_credit_limiter #(.NUM_WF(NUM_WF), .MAX_REQ(MAX_REQ), .TOKENS(TOKENS)) uut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_wf(iss_wf), .iss_op(iss_op),
    .iss_lanes_zero(iss_lanes_zero), .cmp_valid(cmp_valid), .cmp_wf(cmp_wf),
    .cmp_op(cmp_op), .tok_ret(tok_ret), .iss_grant(iss_grant),
    .err_underflow(err_underflow)
  );

  // vector: {is_completion, wf[1:0], op[1:0], expected grant}
  localparam int NV = 12;
  localparam logic [5:0] VEC [NV] = '{
    {1'b0, 2'd3, 2'd2, 1'b1},  // atomic, sum 2
    {1'b0, 2'd3, 2'd3, 1'b1},  // sync, sum 4
    {1'b0, 2'd3, 2'd1, 1'b1},  // store, sum 5
    {1'b0, 2'd3, 2'd0, 1'b1},  // load, sum 6
    {1'b0, 2'd3, 2'd0, 1'b1},  // load, sum 7
    {1'b0, 2'd3, 2'd2, 1'b1},  // atomic at 7, sum 9
    {1'b0, 2'd3, 2'd0, 1'b0},  // refused
    {1'b0, 2'd2, 2'd0, 1'b1},  // other wavefront unaffected
    {1'b1, 2'd3, 2'd0, 1'b0},  // load completes, sum 8
    {1'b0, 2'd3, 2'd0, 1'b0},  // still at limit
    {1'b1, 2'd3, 2'd2, 1'b0},  // atomic completes, sum 6
    {1'b0, 2'd3, 2'd1, 1'b1}   // store granted, sum 7
  };

  task automatic check(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic drive(input bit iv, input int iw, input int io, input bit iz,
                       input bit cv, input int cw, input int co, input bit tr);
    @(negedge clk);
    iss_valid = iv; iss_wf = WW'(iw); iss_op = 2'(io); iss_lanes_zero = iz;
    cmp_valid = cv; cmp_wf = WW'(cw); cmp_op = 2'(co); tok_ret = tr;
    @(negedge clk);
    iss_valid = 0; cmp_valid = 0; tok_ret = 0; iss_lanes_zero = 0;
  endtask

  task automatic issue(input int w, input int op, input bit zero, input bit exp, input string tag);
    drive(1, w, op, zero, 0, 0, 0, 0);
    check(iss_grant, exp, tag);
  endtask

  task automatic complete(input int w, input int op);
    drive(0, 0, 0, 0, 1, w, op, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    do_reset();
    // R9: reset state
    check(iss_grant, 1'b0, "R9 grant after reset");
    check(err_underflow, 1'b0, "R9 error after reset");

    // R1 R2 R3 R10: table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][5]) begin
        complete(int'(VEC[i][4:3]), int'(VEC[i][2:1]));
        check(iss_grant, 1'b0, $sformatf("R3 completion entry %0d", i));
      end else begin
        issue(int'(VEC[i][4:3]), int'(VEC[i][2:1]), 0, VEC[i][0],
              $sformatf("R1/R2/R10 table entry %0d", i));
      end
    end
    check(err_underflow, 1'b0, "R3 no underflow after table");

    // R4 R5 R6: drain the pool
    do_reset();
    for (int r = 0; r < 7; r++) begin
      for (int k = 0; k < MAX_REQ; k++) issue(0, 0, 0, 1'b1, "R4 drain issue");
      issue(0, 0, 0, 1'b0, "R1 drain limit");
      for (int k = 0; k < MAX_REQ; k++) complete(0, 0);
    end
    for (int k = 0; k < 7; k++) issue(0, 0, 0, 1'b1, "R4 drain tail");
    for (int k = 0; k < 7; k++) complete(0, 0);
    issue(1, 0, 1, 1'b1, "R5 lanes-zero grant with one token left");
    issue(1, 0, 0, 1'b1, "R5 last token still present");
    issue(2, 0, 0, 1'b0, "R4 empty pool refuses");
    drive(0, 0, 0, 0, 0, 0, 0, 1);
    issue(2, 0, 0, 1'b1, "R6 returned token granted");
    issue(2, 0, 0, 1'b0, "R6 single return adds one");

    // R7: same-cycle issue and completion
    do_reset();
    for (int k = 0; k < 7; k++) issue(0, 0, 0, 1'b1, "R7 fill");
    drive(1, 0, 0, 0, 1, 0, 0, 0);
    check(iss_grant, 1'b1, "R7 issue with completion");
    issue(0, 0, 0, 1'b1, "R7 count net unchanged");
    issue(0, 0, 0, 1'b0, "R7 limit after both applied");

    // R8: underflow
    do_reset();
    complete(1, 1);
    check(err_underflow, 1'b1, "R8 underflow flag");
    for (int k = 0; k < MAX_REQ; k++) issue(1, 1, 0, 1'b1, "R8 count held at zero");
    issue(1, 1, 0, 1'b0, "R8 limit after held zero");
    check(err_underflow, 1'b1, "R8 flag sticky");

    finish_run();
  end
endmodule